// File: doc/BRIEF.md
# Twiddle ROM Address Generator for an In-Place Radix-2 FFT

This block sits beside the data-address path of a single-butterfly, in-place, decimation-in-time radix-2 FFT engine. For every butterfly it turns the butterfly index into the address of the twiddle coefficient to read from a half-size coefficient ROM. Word p of that ROM holds W^p = exp(-j2πp/N). Each word has an 8-bit real part and an 8-bit imaginary part, both two's complement. Because the ROM holds only half the twiddle set, every address lies in 0 to N/2-1.

The block keeps a stage mask. A start pulse clears the mask and latches the transform size. Each stage-advance pulse shifts the mask left and inserts a 1 at bit 0. The address is the index bit-reversed over the m-1 bits that are active for the size (m = log2 N), then ANDed with the mask. The address is registered, so it arrives one cycle after the index. This matches the latency of the data-address path.

Sequencing uses a four-state machine:
- `S_IDLE`: no transform.
- `S_FIRST`: stage 1, mask all zero.
- `S_MID`: the inner stages.
- `S_LAST`: stage m, mask full.

Its transitions are:
- `start_go` (any state to `S_FIRST` on start).
- `adv_mid` (`S_FIRST` or `S_MID` to `S_MID`).
- `adv_last` (to `S_LAST` when the mask already holds m-2 ones).
- `adv_done` (`S_LAST` to `S_IDLE`).

Top module: `tw_rom_addr_gen`

## Requirements
- R1: After reset, `addr_vld` is 0 and `rom_addr` is 0, and no address is produced until a start pulse.
- R2: A start pulse clears the stage mask, so every address in the first stage is 0 (the W^0 twiddle).
- R3: Each stage-advance pulse during a transform shifts the mask left by one and sets bit 0.
- R4: `rom_addr` equals the index bit-reversed over m-1 bits, ANDed with the mask: bit i of the reversal is index bit m-2-i.
- R5: `mode` encodes the size as 0=256, 1=512, 2=1024, 3=2048 points. Index bits at position m-1 and above are ignored, and every address is below N/2.
- R6: `addr_vld` is 1 exactly one cycle after a cycle in which `bfly_vld` was 1, a transform was running and `start` was 0. Otherwise it is 0, and `bfly_vld` outside a transform produces no address.
- R7: The m-th stage advance ends the transform. Later `bfly_vld` pulses produce no address until the next start.
- R8: A start pulse during a transform restarts it: the mask is cleared and the new `mode` is latched.
- R9: Changes on `mode` between start pulses have no effect on the addresses.
- R10: When `bfly_vld` and `stage_adv` occur in the same cycle, the address uses the mask held before the advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transform: clear the mask and latch the mode |
| stage_adv | input | 1 | Advance to the next FFT stage |
| mode | input | 2 | Transform size select (0=256 … 3=2048) |
| bfly_vld | input | 1 | Butterfly index is valid this cycle |
| bfly_idx | input | 10 | Current butterfly index |
| addr_vld | output | 1 | `rom_addr` is valid |
| rom_addr | output | 10 | Twiddle ROM address p |

## Verification
Every size is swept through all of its stages with a small set of index patterns: all ones, a single low bit, two alternating-bit words, and a word with only high bits set. All ones shows how far the mask has grown. The single low bit and the alternating words expose a wrong reversal width or bit order. The high-bit word shows that bits above the active width are ignored in the smaller sizes. Further scenarios check the following:
- A restart mid-transform into a different size.
- A `mode` change that must be ignored.
- Index and stage advance in the same cycle, which tells whether the mask before or after the advance is used.
- Index pulses in idle and after the final advance.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FIRST = 2'd1,
        S_MID   = 2'd2,
        S_LAST  = 2'd3
    } tw_state_e;

endpackage

// File: rtl/tw_bitrev.sv
module tw_bitrev #(
    parameter int MIN_LOG2N = 8,
    parameter int MODE_W    = 2,
    parameter int IDX_W     = 10
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [MODE_W-1:0] mode_sel,
    output logic [IDX_W-1:0]  rev
);

    localparam int NUM_MODES = 1 << MODE_W;

    logic [NUM_MODES-1:0][IDX_W-1:0] rev_all;

    // One reverser per size: bit i takes index bit (w-1-i), w = log2N - 1
    for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
        localparam int W = MIN_LOG2N - 1 + g;
        for (genvar i = 0; i < IDX_W; i++) begin : g_bit
            if (i < W) begin : g_live
                assign rev_all[g][i] = idx[W-1-i];
            end else begin : g_dead
                assign rev_all[g][i] = 1'b0;
            end
        end
    end

    assign rev = rev_all[mode_sel];

endmodule

// File: rtl/tw_stage_mask.sv
module tw_stage_mask #(
    parameter int MIN_LOG2N = 8,
    parameter int MODE_W    = 2,
    parameter int IDX_W     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_clr,
    input  logic              mask_shift,
    input  logic [MODE_W-1:0] mode_in,
    output logic [IDX_W-1:0]  mask_q,
    output logic [MODE_W-1:0] mode_q,
    output logic              pre_last
);

    // Bit (w-2) of the mask: set while in stage m-1
    localparam int PRE_BASE = MIN_LOG2N - 3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            mode_q <= '0;
        end else if (mask_clr) begin
            mask_q <= '0;
            mode_q <= mode_in;
        end else if (mask_shift) begin
            mask_q <= {mask_q[IDX_W-2:0], 1'b1};
        end
    end

    always_comb begin
        pre_last = mask_q[PRE_BASE + int'(mode_q)];
    end

endmodule

// File: rtl/tw_seq_fsm.sv
module tw_seq_fsm
    import tw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stage_adv,
    input  logic pre_last,
    output logic mask_clr,
    output logic mask_shift,
    output logic run
);

    tw_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        mask_clr   = 1'b0;
        mask_shift = 1'b0;
        run        = (state_q != S_IDLE);
        unique case (state_q)
            S_IDLE: begin
                if (start) begin                 // start_go
                    state_d  = S_FIRST;
                    mask_clr = 1'b1;
                end
            end
            S_FIRST, S_MID: begin
                if (start) begin                 // start_go
                    state_d  = S_FIRST;
                    mask_clr = 1'b1;
                end else if (stage_adv) begin
                    mask_shift = 1'b1;
                    state_d    = pre_last ? S_LAST : S_MID;   // adv_last / adv_mid
                end
            end
            S_LAST: begin
                if (start) begin                 // start_go
                    state_d  = S_FIRST;
                    mask_clr = 1'b1;
                end else if (stage_adv) begin
                    state_d = S_IDLE;            // adv_done
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

endmodule

// File: rtl/tw_rom_addr_gen.sv
module tw_rom_addr_gen #(
    parameter int MIN_LOG2N = 8,
    parameter int MODE_W    = 2,
    parameter int IDX_W     = MIN_LOG2N + (1 << MODE_W) - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stage_adv,
    input  logic [MODE_W-1:0] mode,
    input  logic              bfly_vld,
    input  logic [IDX_W-1:0]  bfly_idx,
    output logic              addr_vld,
    output logic [IDX_W-1:0]  rom_addr
);

    logic              mask_clr, mask_shift, run, pre_last;
    logic [IDX_W-1:0]  mask_q, rev;
    logic [MODE_W-1:0] mode_q;

    tw_seq_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .stage_adv  (stage_adv),
        .pre_last   (pre_last),
        .mask_clr   (mask_clr),
        .mask_shift (mask_shift),
        .run        (run)
    );

    tw_stage_mask #(.MIN_LOG2N(MIN_LOG2N), .MODE_W(MODE_W), .IDX_W(IDX_W)) i_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_clr   (mask_clr),
        .mask_shift (mask_shift),
        .mode_in    (mode),
        .mask_q     (mask_q),
        .mode_q     (mode_q),
        .pre_last   (pre_last)
    );

    tw_bitrev #(.MIN_LOG2N(MIN_LOG2N), .MODE_W(MODE_W), .IDX_W(IDX_W)) i_rev (
        .idx      (bfly_idx),
        .mode_sel (mode_q),
        .rev      (rev)
    );

    logic fire;
    assign fire = run && bfly_vld && !start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_vld <= 1'b0;
            rom_addr <= '0;
        end else begin
            addr_vld <= fire;
            if (fire) rom_addr <= rev & mask_q;
        end
    end

endmodule

// File: rtl/tw_rom_addr_chk.sv
module tw_rom_addr_chk #(
    parameter int MIN_LOG2N = 8,
    parameter int MODE_W    = 2,
    parameter int IDX_W     = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              bfly_vld,
    input logic              run,
    input logic              mask_shift,
    input logic [IDX_W-1:0]  mask_q,
    input logic [MODE_W-1:0] mode_q,
    input logic              addr_vld,
    input logic [IDX_W-1:0]  rom_addr
);

    localparam int HW0 = MIN_LOG2N - 1;

    assert_no_addr_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run || !bfly_vld || start) |=> !addr_vld);

    assert_addr_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_vld |-> ((rom_addr >> (HW0 + int'(mode_q))) == '0));

    assert_mask_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (mask_q == '0));

    assert_mask_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mask_shift |=> (mask_q == (($past(mask_q) << 1) | IDX_W'(1))));

    assert_first_stage_w0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && bfly_vld && !start && mask_q == '0) |=> (rom_addr == '0));

    assert_mask_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q >> (HW0 + int'(mode_q))) == '0);

endmodule

bind tw_rom_addr_gen tw_rom_addr_chk #(.MIN_LOG2N(MIN_LOG2N), .MODE_W(MODE_W), .IDX_W(IDX_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .bfly_vld   (bfly_vld),
    .run        (run),
    .mask_shift (mask_shift),
    .mask_q     (mask_q),
    .mode_q     (mode_q),
    .addr_vld   (addr_vld),
    .rom_addr   (rom_addr)
);

// File: tb/test_tw_rom_addr_gen.sv
module test_tw_rom_addr_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, stage_adv = 1'b0, bfly_vld = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [9:0] bfly_idx = '0;
    logic       addr_vld;
    logic [9:0] rom_addr;

    int n_chk = 0, n_bad = 0;
    logic [9:0] m_mask = '0;   // bench model of the stage mask
    int         m_mode = 0;    // bench model of the latched size

    always #2 clk = ~clk;      // 250 MHz

    tw_rom_addr_gen i_tw_rom_addr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .stage_adv(stage_adv),
        .mode(mode), .bfly_vld(bfly_vld), .bfly_idx(bfly_idx),
        .addr_vld(addr_vld), .rom_addr(rom_addr)
    );

    function automatic logic [9:0] ref_addr(input logic [9:0] ix, input int md, input logic [9:0] mk);
        logic [9:0] r = '0;
        int w = 7 + md;
        for (int i = 0; i < w; i++) r[i] = ix[w-1-i];
        return r & mk;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive one cycle at a falling edge; outputs are read at the next falling edge
    task automatic step(input logic s, input logic a, input logic v, input logic [9:0] ix);
        start = s; stage_adv = a; bfly_vld = v; bfly_idx = ix;
        @(negedge clk);
        start = 0; stage_adv = 0; bfly_vld = 0; bfly_idx = '0;
    endtask

    task automatic do_start(input int md);
        mode = 2'(md);
        step(1, 0, 0, '0);
        m_mask = '0; m_mode = md;
    endtask

    task automatic do_adv();
        step(0, 1, 0, '0);
        m_mask = (m_mask << 1) | 10'd1;
    endtask

    task automatic probe(input string req, input logic [9:0] ix);
        step(0, 0, 1, ix);
        check({req, " vld"}, int'(addr_vld), 1);
        check({req, " addr"}, int'(rom_addr), int'(ref_addr(ix, m_mode, m_mask)));
    endtask

    task automatic t_reset();
        check("R1 vld", int'(addr_vld), 0);
        check("R1 addr", int'(rom_addr), 0);
        step(0, 0, 1, 10'h3FF);
        check("R6 idle bfly", int'(addr_vld), 0);
    endtask

    task automatic t_first_stage();
        do_start(3);
        step(0, 0, 1, 10'h3FF);
        check("R2 w0", int'(rom_addr), 0);
        step(0, 0, 1, 10'h155);
        check("R2 w0 b", int'(rom_addr), 0);
        step(0, 0, 0, '0);
        check("R6 one cycle", int'(addr_vld), 0);
    endtask

    task automatic t_sweep(input int md);
        logic [9:0] pats [5] = '{10'h3FF, 10'h001, 10'h2A5, 10'h15A, 10'h380};
        do_start(md);
        for (int s = 0; s < 8 + md; s++) begin
            foreach (pats[p]) probe("R3 R4 R5 sweep", pats[p]);
            do_adv();
        end
        step(0, 0, 1, 10'h3FF);
        check("R7 after last", int'(addr_vld), 0);
    endtask

    task automatic t_restart();
        do_start(3);
        for (int s = 0; s < 5; s++) do_adv();
        probe("R8 pre", 10'h2A5);
        do_start(0);
        probe("R8 cleared", 10'h3FF);
        do_adv(); do_adv();
        probe("R8 new size", 10'h3FF);
        probe("R8 new size b", 10'h041);
    endtask

    task automatic t_mode_ignore();
        do_start(1);
        do_adv(); do_adv(); do_adv();
        mode = 2'd3;
        probe("R9 latched", 10'h0FF);
        probe("R9 latched b", 10'h001);
    endtask

    task automatic t_same_cycle();
        logic [9:0] old;
        do_start(2);
        do_adv(); do_adv();
        old = m_mask;
        step(0, 1, 1, 10'h3FF);
        check("R10 vld", int'(addr_vld), 1);
        check("R10 old mask", int'(rom_addr), int'(ref_addr(10'h3FF, 2, old)));
        m_mask = (m_mask << 1) | 10'd1;
        probe("R10 new mask", 10'h3FF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_stage();
        for (int md = 0; md < 4; md++) t_sweep(md);
        t_restart();
        t_mode_ignore();
        t_same_cycle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule